// File: doc/BRIEF.md
# Alarm annunciator lamp sequencer

This block is one channel of a plant alarm panel. It watches a single field status line, which is either normal or in alarm, together with two operator pushbuttons: acknowledge and reset. From these it drives a lamp and two hooters. The alarm hooter announces a new alarm. The ring-back hooter announces that the field signal has cleared and is waiting for the operator to reset it.

The channel works through a four-phase ring-back sequence. A new alarm makes the lamp flash fast and sounds the alarm hooter. An acknowledge during that phase turns the lamp steady and silences the hooter. When the field signal returns to normal, the lamp flashes slowly and the ring-back hooter sounds until the operator resets the channel. A return to normal before any acknowledge goes straight to ring-back. A new alarm during ring-back starts the sequence again.

The block also contains a free-running flash divider. It turns the two-bit lamp mode into a physical lamp drive, and the fast rate is a parameter multiple of the slow rate.

Top module: `annun_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no stimulus, lamp_mode is 00 (off) and both hooters are off.
- R2: From the idle phase, sig_alarm=1 at a clock edge makes lamp_mode 11 (fast flash) with alarm_hooter=1 and ringback_hooter=0 after that edge.
- R3: In the fast-flash phase, ack=1 together with sig_alarm=1 makes lamp_mode 01 (steady) with both hooters off after that edge.
- R4: In the fast-flash or steady phase, sig_alarm=0 makes lamp_mode 10 (slow flash) with ringback_hooter=1 and alarm_hooter=0 after that edge. From fast flash this holds even when ack=1 in the same cycle.
- R5: In the slow-flash phase, clr=1 together with sig_alarm=0 makes lamp_mode 00 with both hooters off after that edge.
- R6: In the slow-flash phase, sig_alarm=1 returns lamp_mode to 11 with alarm_hooter=1, even when clr=1 in the same cycle.
- R7: ack has no effect in any phase other than fast flash, and clr has no effect in any phase other than slow flash. The lamp_mode and hooter outputs stay unchanged.
- R8: The two hooters are never on together. alarm_hooter is on only with lamp_mode 11, and ringback_hooter is on only with lamp_mode 10.
- R9: lamp_drive is 0 while lamp_mode is 00 and 1 while lamp_mode is 01.
- R10: lamp_drive toggles every SLOW_HALF/FAST_RATIO cycles in fast flash and every SLOW_HALF cycles in slow flash. With the defaults (16, 4), any 32 consecutive cycles contain 8 changes in fast flash and 2 in slow flash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_alarm | input | 1 | Field status: 1 alarm, 0 normal |
| ack | input | 1 | Operator acknowledge pushbutton |
| clr | input | 1 | Operator reset pushbutton |
| lamp_mode | output | 2 | 00 off, 01 steady, 10 slow flash, 11 fast flash |
| alarm_hooter | output | 1 | Alarm hooter on |
| ringback_hooter | output | 1 | Ring-back hooter on |
| lamp_drive | output | 1 | Physical lamp level after flashing |

## Verification
The phase register is the only register between the inputs and lamp_mode and the hooters. A stimulus held across one rising edge therefore shows on these outputs at the falling edge that follows. Each driver step stamps its expected item with the edge count plus one, and the monitor compares that item only at the first falling edge after that count is reached. lamp_drive depends on the free-running divider and not on the stimulus time, so the flash rates are checked by counting level changes over 32 consecutive falling-edge samples, which does not depend on the divider's phase.

// File: rtl/annun_pkg.sv
`timescale 1ns/1ps
package annun_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_ALERT    = 2'd1,
    ST_ACKED    = 2'd2,
    ST_RINGBACK = 2'd3
  } ann_state_t;

  typedef enum logic [1:0] {
    LAMP_OFF    = 2'b00,
    LAMP_STEADY = 2'b01,
    LAMP_SLOW   = 2'b10,
    LAMP_FAST   = 2'b11
  } lamp_mode_t;

  // Phase transition; a field change takes priority over the pushbuttons.
  function automatic ann_state_t next_state(ann_state_t s, logic alm,
                                            logic ackb, logic clrb);
    ann_state_t n;
    n = s;
    case (s)
      ST_IDLE:     if (alm) n = ST_ALERT;
      ST_ALERT:    if (!alm) n = ST_RINGBACK; else if (ackb) n = ST_ACKED;
      ST_ACKED:    if (!alm) n = ST_RINGBACK;
      ST_RINGBACK: if (alm) n = ST_ALERT; else if (clrb) n = ST_IDLE;
      default:     n = ST_IDLE;
    endcase
    return n;
  endfunction

  function automatic lamp_mode_t mode_of(ann_state_t s);
    case (s)
      ST_ALERT:    return LAMP_FAST;
      ST_ACKED:    return LAMP_STEADY;
      ST_RINGBACK: return LAMP_SLOW;
      default:     return LAMP_OFF;
    endcase
  endfunction

  // Square wave level: high during every odd half-period.
  function automatic logic level_at(int unsigned cnt, int unsigned half);
    return ((cnt / half) % 2) == 1;
  endfunction
endpackage

// File: rtl/annun_fsm.sv
`timescale 1ns/1ps
module annun_fsm
  import annun_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sig_alarm,
  input  logic       ack,
  input  logic       clr,
  output ann_state_t state
);
  ann_state_t st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= next_state(st_q, sig_alarm, ack, clr);
  end

  assign state = st_q;
endmodule

// File: rtl/annun_flash.sv
`timescale 1ns/1ps
module annun_flash
  import annun_pkg::*;
#(
  parameter int unsigned SLOW_HALF  = 16,
  parameter int unsigned FAST_RATIO = 4
)(
  input  logic clk,
  input  logic rst_n,
  output logic slow_lvl,
  output logic fast_lvl
);
  localparam int unsigned PERIOD    = 2 * SLOW_HALF;
  localparam int unsigned FAST_HALF = (SLOW_HALF / FAST_RATIO > 0) ? SLOW_HALF / FAST_RATIO : 1;
  localparam int unsigned CW        = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (cnt_q == CW'(PERIOD - 1))  cnt_q <= '0;
    else                                cnt_q <= cnt_q + 1'b1;
  end

  assign slow_lvl = level_at(32'(cnt_q), SLOW_HALF);
  assign fast_lvl = level_at(32'(cnt_q), FAST_HALF);
endmodule

// File: rtl/annun_out.sv
`timescale 1ns/1ps
module annun_out
  import annun_pkg::*;
(
  input  ann_state_t state,
  input  logic       slow_lvl,
  input  logic       fast_lvl,
  output logic [1:0] lamp_mode,
  output logic       alarm_hooter,
  output logic       ringback_hooter,
  output logic       lamp_drive
);
  lamp_mode_t mode;

  always_comb begin
    mode = mode_of(state);
    case (mode)
      LAMP_STEADY: lamp_drive = 1'b1;
      LAMP_SLOW:   lamp_drive = slow_lvl;
      LAMP_FAST:   lamp_drive = fast_lvl;
      default:     lamp_drive = 1'b0;
    endcase
  end

  assign lamp_mode       = mode;
  assign alarm_hooter    = (state == ST_ALERT);
  assign ringback_hooter = (state == ST_RINGBACK);
endmodule

// File: rtl/annun_seq.sv
`timescale 1ns/1ps
module annun_seq
  import annun_pkg::*;
#(
  parameter int unsigned SLOW_HALF  = 16,
  parameter int unsigned FAST_RATIO = 4
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sig_alarm,
  input  logic       ack,
  input  logic       clr,
  output logic [1:0] lamp_mode,
  output logic       alarm_hooter,
  output logic       ringback_hooter,
  output logic       lamp_drive
);
  ann_state_t state;
  logic       slow_lvl;
  logic       fast_lvl;

  annun_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sig_alarm(sig_alarm), .ack(ack), .clr(clr),
    .state(state)
  );

  annun_flash #(.SLOW_HALF(SLOW_HALF), .FAST_RATIO(FAST_RATIO)) u_flash (
    .clk(clk), .rst_n(rst_n), .slow_lvl(slow_lvl), .fast_lvl(fast_lvl)
  );

  annun_out u_out (
    .state(state), .slow_lvl(slow_lvl), .fast_lvl(fast_lvl),
    .lamp_mode(lamp_mode), .alarm_hooter(alarm_hooter),
    .ringback_hooter(ringback_hooter), .lamp_drive(lamp_drive)
  );
endmodule

// File: rtl/annun_chk.sv
`timescale 1ns/1ps
module annun_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sig_alarm,
  input logic       ack,
  input logic       clr,
  input logic [1:0] lamp_mode,
  input logic       alarm_hooter,
  input logic       ringback_hooter,
  input logic       lamp_drive
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (lamp_mode == 2'b00 && !alarm_hooter && !ringback_hooter)); // R1

  AST_IDLE_TO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_mode == 2'b00 && sig_alarm) |=> (lamp_mode == 2'b11 && alarm_hooter)); // R2

  AST_ACK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_mode == 2'b11 && sig_alarm && ack) |=> (lamp_mode == 2'b01 && !alarm_hooter)); // R3

  AST_RETURN_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((lamp_mode == 2'b11 || lamp_mode == 2'b01) && !sig_alarm)
      |=> (lamp_mode == 2'b10 && ringback_hooter)); // R4

  AST_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_mode == 2'b10 && clr && !sig_alarm) |=> (lamp_mode == 2'b00 && !ringback_hooter)); // R5

  AST_REALARM: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_mode == 2'b10 && sig_alarm) |=> (lamp_mode == 2'b11)); // R6

  AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_mode == 2'b00 && !sig_alarm) |=> $stable(lamp_mode)); // R7

  AST_HOOTER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(alarm_hooter && ringback_hooter)
    && (!alarm_hooter || lamp_mode == 2'b11)
    && (!ringback_hooter || lamp_mode == 2'b10)); // R8

  AST_DRIVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_mode == 2'b00 |-> !lamp_drive) and (lamp_mode == 2'b01 |-> lamp_drive)); // R9
endmodule

bind annun_seq annun_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sig_alarm(sig_alarm), .ack(ack), .clr(clr),
  .lamp_mode(lamp_mode), .alarm_hooter(alarm_hooter),
  .ringback_hooter(ringback_hooter), .lamp_drive(lamp_drive)
);

// File: tb/annun_seq_bench.sv
`timescale 1ns/1ps
module annun_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sig_alarm = 1'b0;
  logic       ack = 1'b0;
  logic       clr = 1'b0;
  logic [1:0] lamp_mode;
  logic       alarm_hooter;
  logic       ringback_hooter;
  logic       lamp_drive;

  annun_seq u_annun_seq (
    .clk(clk), .rst_n(rst_n), .sig_alarm(sig_alarm), .ack(ack), .clr(clr),
    .lamp_mode(lamp_mode), .alarm_hooter(alarm_hooter),
    .ringback_hooter(ringback_hooter), .lamp_drive(lamp_drive)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [1:0] mode;
    logic       ah;
    logic       rh;
    logic       chk_drv;
    logic       drv;
    int         due;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   tick = 0;
  int   n_chk = 0;
  int   n_bad = 0;

  always @(posedge clk) tick <= tick + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Monitor: compares each queued item at the first falling edge after it is due.
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due <= tick) begin
      cur = q.pop_front();
      check({lamp_mode, alarm_hooter, ringback_hooter} == {cur.mode, cur.ah, cur.rh},
            cur.tag, {lamp_mode, alarm_hooter, ringback_hooter},
            {cur.mode, cur.ah, cur.rh});
      check(!(alarm_hooter && ringback_hooter), "R8 hooters both on",
            {alarm_hooter, ringback_hooter}, 0);
      if (cur.chk_drv)
        check(lamp_drive == cur.drv, {cur.tag, " R9 drive"}, lamp_drive, cur.drv);
    end
  end

  // Driver: applies one cycle of inputs and queues the outcome expected after the next edge.
  task automatic step(input logic a, input logic k, input logic c,
                      input logic [1:0] m, input string tag);
    exp_t e;
    @(negedge clk);
    sig_alarm = a; ack = k; clr = c;
    e.mode = m;
    e.ah = (m == 2'b11);
    e.rh = (m == 2'b10);
    e.chk_drv = (m == 2'b00 || m == 2'b01);
    e.drv = (m == 2'b01);
    e.due = tick + 1;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic count_flips(output int n);
    logic prev;
    n = 0;
    @(negedge clk);
    prev = lamp_drive;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (lamp_drive != prev) n++;
      prev = lamp_drive;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int flips;
    repeat (3) @(negedge clk);
    check({lamp_mode, alarm_hooter, ringback_hooter} == 4'b0000, "R1 in reset",
          {lamp_mode, alarm_hooter, ringback_hooter}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({lamp_mode, alarm_hooter, ringback_hooter} == 4'b0000, "R1 after release",
          {lamp_mode, alarm_hooter, ringback_hooter}, 0);

    step(0, 1, 0, 2'b00, "R7 ack in idle");
    step(0, 0, 1, 2'b00, "R7 clr in idle");
    step(1, 0, 0, 2'b11, "R2 idle to fast");
    step(1, 0, 1, 2'b11, "R7 clr in fast");
    step(1, 1, 0, 2'b01, "R3 ack to steady");
    step(1, 1, 0, 2'b01, "R7 ack in steady");
    step(1, 0, 1, 2'b01, "R7 clr in steady");
    step(0, 0, 0, 2'b10, "R4 steady to slow");
    step(0, 1, 0, 2'b10, "R7 ack in slow");
    step(1, 0, 1, 2'b11, "R6 realarm beats clr");
    step(0, 1, 0, 2'b10, "R4 normal beats ack in fast");
    step(0, 0, 1, 2'b00, "R5 clr to off");
    step(1, 0, 0, 2'b11, "R2 second alarm");
    step(0, 0, 0, 2'b10, "R4 fast to slow");
    step(1, 0, 0, 2'b11, "R6 realarm");
    step(1, 0, 0, 2'b11, "R2 alarm held");
    repeat (2) @(negedge clk);
    check(q.size() == 0, "queue drained", q.size(), 0);

    count_flips(flips);
    check(flips == 8, "R10 fast flips per 32", flips, 8);
    step(0, 0, 0, 2'b10, "R4 into slow for rate");
    repeat (2) @(negedge clk);
    count_flips(flips);
    check(flips == 2, "R10 slow flips per 32", flips, 2);
    finish_run();
  end
endmodule